// File: doc/BRIEF.md
# Multicore Reset and Boot Controller

This block is a small register file on a 32-bit word bus that lets software reset, start and stop the processor cores of a four-core cluster, and pulse the reset of two auxiliary units. Software loads a start address and an argument word into general-purpose registers, then writes the control register. The block compares the written control word with the stored one and acts only on bits that differ: an enable bit that flips produces a power-on or power-off request for its core, and a reset bit that flips to one produces a single-cycle reset strobe.

Requests leave the block as per-core strobes, registered and valid in the cycle after the bus write. A power-on strobe comes with that core's start address and argument, captured from the register pair at the moment of the write. Every command bit clears itself, so it always reads back as zero.

The read path is combinational: a read request returns the addressed register in the same cycle.

Top module: `rcb_top`

## Requirements
- R1: After reset, the control register (word 0) reads 0x521, the reset status register (word 2) reads 0x1, the interrupt mask register (word 4) reads 0x1F, and every other register reads 0.
- R2: The register index is the byte address shifted right by two within a 4 KiB window. An access with address bits [1:0] not zero is refused: the read returns 0 and the write changes nothing.
- R3: A read of an index of 16 or more returns 0. A write to such an index leaves every register unchanged.
- R4: A write to any register other than word 0 stores the written value unchanged. Word order: 0 control, 1 boot mode A, 2 reset status, 3 interrupt status, 4 interrupt mask, 5 boot mode B, 6 to 15 general-purpose registers G1 to G10.
- R5: When a control write changes the enable bit of core 1, 2 or 3 (bits 22, 23, 24) to 1, that core's power-on strobe is raised. Its start address is G3, G5 or G7 (words 8, 10, 12) and its argument is G4, G6 or G8 (words 9, 11, 13).
- R6: When a control write changes the enable bit of core 1, 2 or 3 to 0, that core's power-off strobe is raised.
- R7: A control write that flips a core's enable bit gives that core no reset strobe, and that core's reset bit is stored as 0.
- R8: A control write that sets a core reset bit (bits 13 to 16 for cores 0 to 3) raises that core's reset strobe. The bit reads back as 0.
- R9: The auxiliary reset bits (bit 3 and bit 12) always read back as 0 after a control write.
- R10: A control write whose enable bits equal the stored ones raises no power-on or power-off strobe.
- R11: All strobes are high for exactly the one cycle after the control write. They stay low after any other write, read or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus access request in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address within the 4 KiB window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the read request |
| core_rst_o | output | 4 | Per-core reset strobe |
| core_on_o | output | 4 | Per-core power-on strobe (bit 0 never set) |
| core_off_o | output | 4 | Per-core power-off strobe (bit 0 never set) |
| core_start_addr_o | output | 128 | Start address, 32 bits per core, core n at [32n+31:32n], valid with its power-on strobe |
| core_start_arg_o | output | 128 | Argument word, same layout, valid with its power-on strobe |

## Verification
The hardest case to reach is a single control write that flips one core's enable bit and also sets reset bits, both for that same core and for others. In that case the reset of the switching core must be absorbed while the others still pulse. Such writes are rare unless the enable bits are pushed away from their stored state on purpose. The random phase therefore draws enable and reset fields independently and mixes in frequent re-writes of the stored enables. The directed phase builds the exact overlap case, including an enable flip with a reset request for the same core and a write that repeats the stored enables unchanged.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  localparam int NCORE   = 4;
  localparam int DW      = 32;
  localparam int CTL_IDX = 0;
  localparam int RST_LSB = 13;   // core n reset at RST_LSB + n
  localparam int EN_LSB  = 21;   // core n enable at EN_LSB + n, n >= 1
  localparam int AUX_A   = 3;
  localparam int AUX_B   = 12;
  localparam int GPR_BASE = 6;   // word index of G1

  typedef struct packed {
    logic [DW-1:0]    nv;
    logic [NCORE-1:0] rst;
    logic [NCORE-1:0] on;
    logic [NCORE-1:0] off;
  } ctl_eff_t;

  function automatic logic [DW-1:0] reg_reset_val(input int idx);
    case (idx)
      0:       return 32'h0000_0521;
      2:       return 32'h0000_0001;
      4:       return 32'h0000_001F;
      default: return '0;
    endcase
  endfunction

  // word index holding the start address of core c; argument is the next word
  function automatic int start_idx(input int c);
    return GPR_BASE + 2 * c;
  endfunction

  // effect of writing w over the stored control word old
  function automatic ctl_eff_t ctl_apply(input logic [DW-1:0] old, input logic [DW-1:0] w);
    logic [DW-1:0] chg;
    ctl_eff_t e;
    chg   = old ^ w;
    e.nv  = w;
    e.rst = '0;
    e.on  = '0;
    e.off = '0;
    for (int c = NCORE - 1; c >= 1; c--) begin
      if (chg[EN_LSB + c]) begin
        if (w[EN_LSB + c]) e.on[c] = 1'b1;
        else               e.off[c] = 1'b1;
        e.nv[RST_LSB + c] = 1'b0;
        chg[RST_LSB + c]  = 1'b0;
      end
    end
    for (int c = 0; c < NCORE; c++) begin
      if (chg[RST_LSB + c]) begin
        e.rst[c] = 1'b1;
        e.nv[RST_LSB + c] = 1'b0;
      end
    end
    if (chg[AUX_A]) e.nv[AUX_A] = 1'b0;
    if (chg[AUX_B]) e.nv[AUX_B] = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/rcb_regfile.sv
module rcb_regfile
  import rcb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [SEL_W-1:0]       wr_sel_i,
  input  logic [DW-1:0]          wr_val_i,
  output logic [NUM_REGS*DW-1:0] regs_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   q <= reg_reset_val(i);
      else if (wr_en_i && wr_sel_i == SEL_W'(i))     q <= wr_val_i;
    end
    assign regs_o[i*DW +: DW] = q;
  end

endmodule

// File: rtl/rcb_cmd.sv
module rcb_cmd
  import rcb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_wr_i,
  input  logic [NCORE-1:0]    rst_req_i,
  input  logic [NCORE-1:0]    on_req_i,
  input  logic [NCORE-1:0]    off_req_i,
  input  logic [NCORE*DW-1:0] start_src_i,
  input  logic [NCORE*DW-1:0] arg_src_i,
  output logic [NCORE-1:0]    rst_o,
  output logic [NCORE-1:0]    on_o,
  output logic [NCORE-1:0]    off_o,
  output logic [NCORE*DW-1:0] start_o,
  output logic [NCORE*DW-1:0] arg_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_o <= '0;
      on_o  <= '0;
      off_o <= '0;
    end else begin
      rst_o <= ctl_wr_i ? rst_req_i : '0;
      on_o  <= ctl_wr_i ? on_req_i  : '0;
      off_o <= ctl_wr_i ? off_req_i : '0;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [DW-1:0] a_q, g_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        g_q <= '0;
      end else if (ctl_wr_i && on_req_i[c]) begin
        a_q <= start_src_i[c*DW +: DW];
        g_q <= arg_src_i[c*DW +: DW];
      end
    end
    assign start_o[c*DW +: DW] = a_q;
    assign arg_o[c*DW +: DW]   = g_q;
  end

  // R7: a core changing power state is never reset by the same write
  assert_no_rst_on_switch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((on_o | off_o) & rst_o) == '0);

  // R11: every strobe traces back to a control write one cycle earlier
  assert_strobe_after_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o != '0 || on_o != '0 || off_o != '0) |-> $past(ctl_wr_i));

  // R5/R6: on and off never both requested for one core
  assert_on_off_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_o & off_o) == '0);

endmodule

// File: rtl/rcb_top.sv
module rcb_top
  import rcb_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 16,
  localparam int IDX_W = ADDR_W - 2,
  localparam int SEL_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output logic [DW-1:0]       bus_rdata_o,
  output logic [NCORE-1:0]    core_rst_o,
  output logic [NCORE-1:0]    core_on_o,
  output logic [NCORE-1:0]    core_off_o,
  output logic [NCORE*DW-1:0] core_start_addr_o,
  output logic [NCORE*DW-1:0] core_start_arg_o
);

  logic [IDX_W-1:0]       idx;
  logic [SEL_W-1:0]       sel;
  logic                   aligned, in_range, acc_ok, acc_wr, ctl_wr, bad_wr;
  logic [NUM_REGS*DW-1:0] regs_flat;
  logic [DW-1:0]          regs_a [NUM_REGS];
  logic [DW-1:0]          wr_val;
  ctl_eff_t               eff;
  logic [NCORE*DW-1:0]    start_src, arg_src;

  assign idx      = bus_addr_i[ADDR_W-1:2];
  assign sel      = idx[SEL_W-1:0];
  assign aligned  = (bus_addr_i[1:0] == 2'b00);
  assign in_range = (idx < IDX_W'(NUM_REGS));
  assign acc_ok   = bus_valid_i && aligned && in_range;
  assign acc_wr   = acc_ok && bus_write_i;
  assign ctl_wr   = acc_wr && (sel == SEL_W'(CTL_IDX));
  assign bad_wr   = bus_valid_i && bus_write_i && !(aligned && in_range);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
    assign regs_a[i] = regs_flat[i*DW +: DW];
  end

  assign eff    = ctl_apply(regs_a[CTL_IDX], bus_wdata_i);
  assign wr_val = ctl_wr ? eff.nv : bus_wdata_i;

  assign bus_rdata_o = (acc_ok && !bus_write_i) ? regs_a[sel] : '0;

  for (genvar c = 0; c < NCORE; c++) begin : g_src
    if (c == 0) begin : g_none
      assign start_src[c*DW +: DW] = '0;
      assign arg_src[c*DW +: DW]   = '0;
    end else begin : g_pair
      assign start_src[c*DW +: DW] = regs_a[start_idx(c)];
      assign arg_src[c*DW +: DW]   = regs_a[start_idx(c) + 1];
    end
  end

  rcb_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (acc_wr),
    .wr_sel_i (sel),
    .wr_val_i (wr_val),
    .regs_o   (regs_flat)
  );

  rcb_cmd u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (ctl_wr),
    .rst_req_i   (eff.rst),
    .on_req_i    (eff.on),
    .off_req_i   (eff.off),
    .start_src_i (start_src),
    .arg_src_i   (arg_src),
    .rst_o       (core_rst_o),
    .on_o        (core_on_o),
    .off_o       (core_off_o),
    .start_o     (core_start_addr_o),
    .arg_o       (core_start_arg_o)
  );

  // R2/R3: a refused or out-of-window write changes no register
  assert_bad_write_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bad_wr) |-> $stable(regs_flat));

  // R4: plain register write stores the data as given
  assert_plain_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_wr && !ctl_wr) |-> regs_a[$past(sel)] == $past(bus_wdata_i));

  // R8/R9: command bits never remain set after a control write
  assert_cmd_bits_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_wr) |-> (regs_a[CTL_IDX][RST_LSB +: NCORE] == '0 &&
                       !regs_a[CTL_IDX][AUX_A] && !regs_a[CTL_IDX][AUX_B]));

  // R5: core 1 start address is the G3 word seen at the write
  assert_core1_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_on_o[1] |-> (core_start_addr_o[DW +: DW] == $past(regs_a[start_idx(1)]) &&
                      core_start_arg_o[DW +: DW] == $past(regs_a[start_idx(1) + 1])));

endmodule

// File: tb/rcb_top_test.sv
module rcb_top_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0, wr = 1'b0;
  logic [11:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [3:0]   c_rst, c_on, c_off;
  logic [127:0] s_addr, s_arg;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m [16];

  always #10 clk = ~clk;

  rcb_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .core_rst_o(c_rst), .core_on_o(c_on), .core_off_o(c_off),
    .core_start_addr_o(s_addr), .core_start_arg_o(s_arg)
  );

  function automatic logic [31:0] cleared_bits();
    return (32'hF << 13) | (32'h1 << 12) | (32'h1 << 3);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    valid = 1; wr = 0; addr = a;
    #1 chk(req, 128'(rdata), 128'(exp));
    @(negedge clk);
    valid = 0;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    logic [2:0] en_chg;
    logic [3:0] e_rst, e_on, e_off;
    logic [31:0] gs [4], ga [4];
    logic ctl, ok;
    ok  = (a[1:0] == 2'b00) && (a[11:2] < 16);
    ctl = ok && (a[11:2] == 0);
    en_chg = m[0][24:22] ^ d[24:22];
    e_rst  = d[16:13] & (m[0][16:13] ^ d[16:13]) & ~{en_chg, 1'b0};
    e_on   = ctl ? {en_chg & d[24:22], 1'b0} : 4'h0;
    e_off  = ctl ? {en_chg & ~d[24:22], 1'b0} : 4'h0;
    if (!ctl) e_rst = 4'h0;
    for (int c = 1; c < 4; c++) begin
      gs[c] = m[6 + 2*c];
      ga[c] = m[7 + 2*c];
    end
    @(negedge clk);
    valid = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; wr = 0;
    if (ctl) m[0] = d & ~cleared_bits();
    else if (ok) m[a[5:2]] = d;
    chk("R8 reset strobe", 128'(c_rst), 128'(e_rst));
    chk("R5 on strobe", 128'(c_on), 128'(e_on));
    chk("R6 off strobe", 128'(c_off), 128'(e_off));
    for (int c = 1; c < 4; c++)
      if (e_on[c]) begin
        chk("R5 start address", 128'(s_addr[c*32 +: 32]), 128'(gs[c]));
        chk("R5 start argument", 128'(s_arg[c*32 +: 32]), 128'(ga[c]));
      end
    @(negedge clk);
    chk("R11 strobes drop", 128'({c_rst, c_on, c_off}), 128'(0));
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 16; i++) bus_read(12'(i * 4), m[i], req);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    repeat (198000) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) m[i] = 0;
    m[0] = 32'h521; m[2] = 32'h1; m[4] = 32'h1F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 idle after reset", 128'({c_rst, c_on, c_off}), 128'(0));
    read_all("R1 reset value");

    // R4 general-purpose pairs and other words
    for (int i = 1; i < 16; i++) bus_write(12'(i * 4), 32'hA000_0000 + 32'(i * 32'h111));
    read_all("R4 stored value");

    // R5 power on core 1 and 3 together, with a reset of core 0
    bus_write(12'h000, (32'h1 << 22) | (32'h1 << 24) | (32'h1 << 13));
    bus_read(12'h000, m[0], "R8 reset bit reads zero");
    // R10 repeat stored enables: no power strobes
    bus_write(12'h000, m[0]);
    // R7 flip core 2 on while requesting resets on cores 2 and 3
    bus_write(12'h000, m[0] | (32'h1 << 23) | (32'h1 << 15) | (32'h1 << 16));
    bus_read(12'h000, m[0], "R7 reset bit stored zero");
    // R6 switch all off, R9 aux bits
    bus_write(12'h000, (32'h1 << 3) | (32'h1 << 12));
    bus_read(12'h000, m[0], "R9 aux bits read zero");
    // R3 out of range and R2 misaligned
    bus_write(12'h040, 32'hDEAD_BEEF);
    bus_write(12'hFFC, 32'hDEAD_BEEF);
    bus_write(12'h02A, 32'hDEAD_BEEF);
    bus_read(12'h040, 32'h0, "R3 out of range read");
    bus_read(12'h021, 32'h0, "R2 misaligned read");
    read_all("R3 file unchanged");

    for (int n = 0; n < 300; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        logic [31:0] d = $urandom;
        if ($urandom_range(0, 1) == 1) d[24:22] = m[0][24:22];
        bus_write(12'h000, d);
      end else if (op < 7) begin
        logic [11:0] a = 12'($urandom_range(1, 19) * 4);
        if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
        bus_write(a, $urandom);
      end else begin
        int i = $urandom_range(0, 15);
        bus_read(12'(i * 4), m[i], "R4 random readback");
      end
    end
    read_all("R4 final readback");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule